// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers up to 63 level-sensitive, active-high interrupt requests and presents the single most urgent one to a processor. Each source has an 8-bit control byte that packs a 3-bit interrupt level and a 3-bit priority within that level. A 64-bit mask, split into two 32-bit words, blocks individual sources. Bit 0 of the low word is not a source: it is a global mask-all switch.

A small register bus reads and writes the two mask words and the 64 control bytes. Every cycle the controller picks the winning pending, unmasked, configured source. It registers the winner's level, its vector number (64 plus the slot number) and an interrupt line qualified by a 3-bit processor mask. An acknowledge strobe latches the current vector so that the processor can read it.

Slots 57 to 63 carry hard-wired levels 1 to 7 and cannot be reprogrammed. Slot 56 and slot 0 hold no source.

Top module: `icu_top`

## Requirements
- R1: After reset both mask words read 0xFFFFFFFF, every programmable control byte reads 0, the level output is 0, the vector output is 64, the interrupt line is low and the acknowledge vector is 64.
- R2: The bus map is: address 0x00 holds the low mask word (slots 0–31), 0x01 holds the high mask word (slots 32–63), and 0x40+n holds the control byte of slot n in data bits 7:0. Programmable registers read back exactly what was written, and reading has no side effect.
- R3: A mask bit at 1 blocks its source. Slot n maps to bit n[4:0] of the word that n[5] selects.
- R4: While bit 0 of the low mask word is 1, the level output is 0 one cycle later, whatever the other mask bits, controls and requests hold.
- R5: A control byte holds the level in bits 5:3 and the priority in bits 2:0. The winner has the highest level, and within that level the highest priority.
- R6: When several candidates have identical level and priority, the lowest slot number wins.
- R7: A source whose control byte is 0 never wins, even when it is unmasked and requesting.
- R8: Writes to slot 0's control byte are ignored and it reads 0.
- R9: Slots 57 to 63 read the fixed value {2'b00, slot-56, 3'b100}, and writes to them are ignored. Slot 56 reads 0 and never wins.
- R10: One clock after the inputs and registers settle, the level output shows the winner's level and the vector output shows 64 plus the winner's slot. With no winner these outputs are 0 and 64.
- R11: The interrupt line, registered with the level, is high when the level exceeds the processor mask input or when the level is 7.
- R12: On a clock edge with the acknowledge strobe high, the acknowledge vector takes the current vector output. It holds that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 63 | Request lines for slots 1 to 63 (bit n is slot n) |
| cpu_mask_i | input | 3 | Processor interrupt mask level |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 7 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| int_level_o | output | 3 | Registered winning level, 0 when idle |
| int_vec_o | output | 7 | Registered vector, 64 plus winning slot |
| irq_o | output | 1 | Registered interrupt request to processor |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_o | output | 7 | Vector latched on acknowledge |

## Verification
The properties assume that the acknowledge strobe and the requests are driven synchronously. They also assume that software never gives an active source a level of 0 with a nonzero priority, because such a winner would show a level of 0 alongside a real vector. The stimulus changes inputs only just after a rising edge and configures every enabled source with a nonzero level. The deliberate ties in the stimulus use the same level and priority, which probes the lowest-slot rule without breaking that assumption.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int DEF_NSLOT      = 64;
    localparam int DEF_FIXED_BASE = 56;
    localparam int DEF_VEC_BASE   = 64;
    localparam int DEF_REG_W      = 32;
    localparam logic [2:0] FIXED_PRI = 3'd4;

    // Per-source control byte
    typedef struct packed {
        logic [1:0] spare;
        logic [2:0] level;
        logic [2:0] prio;
    } ctrl_t;

    // Hard-wired control value for slots at or above the fixed base
    function automatic ctrl_t fixed_ctrl(input int slot, input int base);
        ctrl_t c;
        c = '0;
        if (slot > base) begin
            c.level = 3'(slot - base);
            c.prio  = FIXED_PRI;
        end
        return c;
    endfunction

endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int NSLOT      = DEF_NSLOT,
    parameter int FIXED_BASE = DEF_FIXED_BASE,
    parameter int REG_W      = DEF_REG_W,
    localparam int SRC_W     = $clog2(NSLOT),
    localparam int ADDR_W    = SRC_W + 1,
    localparam int NWORD     = NSLOT / REG_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [REG_W-1:0]          rdata,
    output logic [NSLOT-1:0]          mask_o,
    output ctrl_t [NSLOT-1:0]         ctrl_o
);

    logic              sel_ctrl;
    logic [SRC_W-1:0]  sel_idx;
    logic              ctrl_we;

    assign sel_ctrl = addr[ADDR_W-1];
    assign sel_idx  = addr[SRC_W-1:0];
    assign ctrl_we  = wr_en && sel_ctrl;

    // Mask words, reset to all blocked
    for (genvar w = 0; w < NWORD; w++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_o[w*REG_W +: REG_W] <= '1;
            end else if (wr_en && !sel_ctrl && sel_idx == SRC_W'(w)) begin
                mask_o[w*REG_W +: REG_W] <= wdata;
            end
        end
    end

    // Control bytes: slot 0 empty, programmable range, fixed range
    for (genvar s = 0; s < NSLOT; s++) begin : g_ctrl
        if (s == 0) begin : g_none
            assign ctrl_o[s] = '0;
        end else if (s < FIXED_BASE) begin : g_prog
            ctrl_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (ctrl_we && sel_idx == SRC_W'(s)) begin
                    q <= ctrl_t'(wdata[7:0]);
                end
            end
            assign ctrl_o[s] = q;
        end else begin : g_fixed
            assign ctrl_o[s] = fixed_ctrl(s, FIXED_BASE);
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata = {{(REG_W-8){1'b0}}, ctrl_o[sel_idx]};
        end else begin
            for (int w = 0; w < NWORD; w++) begin
                if (sel_idx == SRC_W'(w)) begin
                    rdata = mask_o[w*REG_W +: REG_W];
                end
            end
        end
    end

endmodule

// File: rtl/icu_arb.sv
module icu_arb
    import icu_pkg::*;
#(
    parameter int NSLOT  = DEF_NSLOT,
    localparam int SRC_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]  req,
    input  logic [NSLOT-1:0]  mask,
    input  ctrl_t [NSLOT-1:0] ctrl,
    output logic              found,
    output logic [SRC_W-1:0]  src,
    output logic [2:0]        level
);

    logic [5:0] best_key;

    // Linear scan with strict compare: ties keep the lower slot
    always_comb begin
        found    = 1'b0;
        src      = '0;
        best_key = '0;
        for (int i = 1; i < NSLOT; i++) begin
            if (req[i] && !mask[i] && !mask[0] && ctrl[i] != '0 &&
                (!found || {ctrl[i].level, ctrl[i].prio} > best_key)) begin
                found    = 1'b1;
                src      = SRC_W'(i);
                best_key = {ctrl[i].level, ctrl[i].prio};
            end
        end
        level = best_key[5:3];
    end

endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int NSLOT      = DEF_NSLOT,
    parameter int FIXED_BASE = DEF_FIXED_BASE,
    parameter int VEC_BASE   = DEF_VEC_BASE,
    parameter int REG_W      = DEF_REG_W,
    localparam int SRC_W     = $clog2(NSLOT),
    localparam int ADDR_W    = SRC_W + 1,
    localparam int VEC_W     = $clog2(VEC_BASE + NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSLOT-1:1]  req_i,
    input  logic [2:0]        cpu_mask_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic [2:0]        int_level_o,
    output logic [VEC_W-1:0]  int_vec_o,
    output logic              irq_o,
    input  logic              ack_i,
    output logic [VEC_W-1:0]  ack_vec_o
);

    logic [NSLOT-1:0]  mask_w;
    ctrl_t [NSLOT-1:0] ctrl_w;
    logic [NSLOT-1:0]  req_all;
    logic              win_found;
    logic [SRC_W-1:0]  win_src;
    logic [2:0]        win_level;
    logic [VEC_W-1:0]  win_vec;
    logic              win_irq;

    assign req_all = {req_i, 1'b0};

    icu_regs #(
        .NSLOT(NSLOT), .FIXED_BASE(FIXED_BASE), .REG_W(REG_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .rdata(bus_rdata_o),
        .mask_o(mask_w), .ctrl_o(ctrl_w)
    );

    icu_arb #(.NSLOT(NSLOT)) u_arb (
        .req(req_all), .mask(mask_w), .ctrl(ctrl_w),
        .found(win_found), .src(win_src), .level(win_level)
    );

    assign win_vec = win_found ? VEC_W'(VEC_BASE) + VEC_W'(win_src) : VEC_W'(VEC_BASE);
    assign win_irq = (win_level > cpu_mask_i) || (win_level == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            int_level_o <= '0;
            int_vec_o   <= VEC_W'(VEC_BASE);
            irq_o       <= 1'b0;
            ack_vec_o   <= VEC_W'(VEC_BASE);
        end else begin
            int_level_o <= win_level;
            int_vec_o   <= win_vec;
            irq_o       <= win_irq;
            if (ack_i) begin
                ack_vec_o <= int_vec_o;
            end
        end
    end

endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
    parameter int VEC_W    = 7,
    parameter int VEC_BASE = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             maskall,
    input logic [2:0]       int_level,
    input logic [VEC_W-1:0] int_vec,
    input logic             irq,
    input logic             ack,
    input logic [VEC_W-1:0] ack_vec
);

    // R4: global mask-all silences the level output on the next cycle
    a_r4_maskall_silences: assert property (@(posedge clk) disable iff (rst)
        maskall |=> int_level == 3'd0);

    // R11: level 7 is raised regardless of the processor mask
    a_r11_top_level_raised: assert property (@(posedge clk) disable iff (rst)
        int_level == 3'd7 |-> irq);

    // R11: no interrupt while idle
    a_r11_idle_not_raised: assert property (@(posedge clk) disable iff (rst)
        int_level == 3'd0 |-> !irq);

    // R10: a nonzero level always comes with a real source vector
    a_r10_level_has_source: assert property (@(posedge clk) disable iff (rst)
        int_level != 3'd0 |-> int_vec != VEC_W'(VEC_BASE));

    // R12: strobe captures the presented vector
    a_r12_ack_capture: assert property (@(posedge clk) disable iff (rst)
        ack |=> ack_vec == $past(int_vec));

    // R12: without a strobe the latched vector holds
    a_r12_ack_hold: assert property (@(posedge clk) disable iff (rst)
        !ack |=> $stable(ack_vec));

endmodule

bind icu_top icu_chk u_chk (
    .clk(clk), .rst(rst), .maskall(mask_w[0]), .int_level(int_level_o),
    .int_vec(int_vec_o), .irq(irq_o), .ack(ack_i), .ack_vec(ack_vec_o)
);

// File: tb/icu_top_tb_top.sv
module icu_top_tb_top;

    localparam logic [6:0] A_MLO = 7'h00;
    localparam logic [6:0] A_MHI = 7'h01;

    typedef enum {K_OUT, K_RD, K_ACK} kind_e;
    typedef struct {
        kind_e       kind;
        string       tag;
        logic [2:0]  lvl;
        logic [6:0]  vec;
        logic        irq;
        logic [31:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:1] req = '0;
    logic [2:0]  cpu_mask = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  int_level;
    logic [6:0]  int_vec;
    logic        irq;
    logic        ack = 1'b0;
    logic [6:0]  ack_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    icu_top dut_i (
        .clk(clk), .rst(rst), .req_i(req), .cpu_mask_i(cpu_mask),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .int_level_o(int_level), .int_vec_o(int_vec),
        .irq_o(irq), .ack_i(ack), .ack_vec_o(ack_vec)
    );

    // Monitor: pops one expectation per falling edge
    always @(negedge clk) begin
        item_t it;
        if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            n_chk++;
            case (it.kind)
                K_OUT: if (int_level !== it.lvl || int_vec !== it.vec || irq !== it.irq) begin
                    n_fail++;
                    $display("FAIL %s: lvl/vec/irq got %0d/%0d/%0d exp %0d/%0d/%0d",
                             it.tag, int_level, int_vec, irq, it.lvl, it.vec, it.irq);
                end
                K_RD: if (bus_rdata !== it.data) begin
                    n_fail++;
                    $display("FAIL %s: rdata got %h exp %h", it.tag, bus_rdata, it.data);
                end
                default: if (ack_vec !== it.vec) begin
                    n_fail++;
                    $display("FAIL %s: ack_vec got %0d exp %0d", it.tag, ack_vec, it.vec);
                end
            endcase
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(kind_e k, string tag, logic [2:0] l, logic [6:0] v, logic i, logic [31:0] d);
        item_t it;
        it.kind = k; it.tag = tag; it.lvl = l; it.vec = v; it.irq = i; it.data = d;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        step();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [6:0] a, logic [31:0] exp);
        step();
        bus_addr = a;
        push(K_RD, tag, 3'd0, 7'd0, 1'b0, exp);
    endtask

    task automatic exp_out(string tag, logic [2:0] l, logic [6:0] v, logic i);
        step();
        push(K_OUT, tag, l, v, i, 32'd0);
    endtask

    task automatic do_ack(string tag, logic [6:0] v);
        step();
        ack = 1'b1;
        step();
        ack = 1'b0;
        push(K_ACK, tag, 3'd0, v, 1'b0, 32'd0);
    endtask

    task automatic chk_ack(string tag, logic [6:0] v);
        step();
        push(K_ACK, tag, 3'd0, v, 1'b0, 32'd0);
    endtask

    function automatic logic [6:0] ca(int n);
        return 7'h40 | 7'(n);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        exp_out("R1 reset outputs", 3'd0, 7'd64, 1'b0);
        chk_ack("R1 reset ack vector", 7'd64);
        rd("R1 mask low reset", A_MLO, 32'hFFFF_FFFF);
        rd("R1 mask high reset", A_MHI, 32'hFFFF_FFFF);
        rd("R1 ctrl reset", ca(5), 32'h0);
        // R2 R5 control readback, read twice
        wr(ca(5), 32'h0000_002B);
        rd("R2 ctrl readback", ca(5), 32'h2B);
        rd("R2 ctrl reread", ca(5), 32'h2B);
        // R3 masked by reset value
        req[5] = 1'b1;
        exp_out("R3 masked source blocked", 3'd0, 7'd64, 1'b0);
        // R4 writing 1 keeps mask-all
        wr(A_MLO, 32'h1);
        exp_out("R4 mask-all blocks", 3'd0, 7'd64, 1'b0);
        wr(A_MLO, 32'h0);
        exp_out("R10 single winner", 3'd5, 7'd69, 1'b1);
        // R11 processor mask
        cpu_mask = 3'd5;
        exp_out("R11 level equal to mask", 3'd5, 7'd69, 1'b0);
        cpu_mask = 3'd4;
        exp_out("R11 level above mask", 3'd5, 7'd69, 1'b1);
        // R3 high word, R5 priority within level
        wr(ca(40), 32'h2E);
        wr(A_MHI, 32'hFFFF_FEFF);
        rd("R2 mask high readback", A_MHI, 32'hFFFF_FEFF);
        req[40] = 1'b1;
        exp_out("R5 higher priority wins", 3'd5, 7'd104, 1'b1);
        wr(ca(20), 32'h30);
        req[20] = 1'b1;
        exp_out("R5 higher level wins", 3'd6, 7'd84, 1'b1);
        wr(A_MLO, 32'h0010_0000);
        rd("R2 mask low readback", A_MLO, 32'h0010_0000);
        exp_out("R3 low word bit masks source", 3'd5, 7'd104, 1'b1);
        // R6 tie
        wr(ca(10), 32'h2E);
        req[10] = 1'b1;
        exp_out("R6 tie lowest slot", 3'd5, 7'd74, 1'b1);
        // R7 unconfigured
        req = '0;
        req[12] = 1'b1;
        exp_out("R7 zero control never wins", 3'd0, 7'd64, 1'b0);
        // R8 slot 0
        wr(ca(0), 32'h3F);
        rd("R8 slot0 reads zero", ca(0), 32'h0);
        // R9 fixed slots
        rd("R9 slot63 fixed", ca(63), 32'h3C);
        rd("R9 slot57 fixed", ca(57), 32'h0C);
        rd("R9 slot56 empty", ca(56), 32'h0);
        wr(ca(63), 32'h01);
        rd("R9 slot63 write ignored", ca(63), 32'h3C);
        wr(A_MHI, 32'h00FF_FFFF);
        req = '0;
        req[56] = 1'b1;
        cpu_mask = 3'd7;
        exp_out("R9 slot56 never wins", 3'd0, 7'd64, 1'b0);
        req[57] = 1'b1;
        exp_out("R9 fixed level one", 3'd1, 7'd121, 1'b0);
        req[63] = 1'b1;
        exp_out("R11 level seven always raised", 3'd7, 7'd127, 1'b1);
        // R12 acknowledge
        do_ack("R12 ack captures vector", 7'd127);
        req = '0;
        exp_out("R10 idle after release", 3'd0, 7'd64, 1'b0);
        chk_ack("R12 ack vector holds", 7'd127);
        do_ack("R12 second ack", 7'd64);
        // R4 mask-all overrides level seven
        req[63] = 1'b1;
        wr(A_MLO, 32'h1);
        exp_out("R4 mask-all beats level seven", 3'd0, 7'd64, 1'b0);
        repeat (3) step();
        finish_run();
    end

endmodule